// File: doc/BRIEF.md
# Limp-Home Clock Loss Supervisor

This block watches whether the external oscillator is still running. When it stops, the block moves the system into a fallback clocking state called limp-home mode. All of its logic runs on the fallback clock, which is always present.

On entry to limp-home mode the block does four things:
- It forces the PLL clock-source select low.
- It sends every module clock group to the fallback clock.
- It keeps the clock monitor switched on, whatever software has programmed.
- It saves the clock-source selects that were in force.

It does not leave limp-home mode as soon as the clock-present indication returns. Recovery is tested only at the mid-point of a free-running counter that wraps at 2^CNT_W. With the default width this gives one test every 8192 fallback cycles. On exit the saved selects go back onto the outputs. If both the auto-lock bit and the PLL select bit are set in the saved copy, the block also gives a one-cycle relock request.

Each change of mode, in either direction, sets a sticky change flag. Software clears this flag with a write-one-to-clear strobe. The interrupt line follows the flag, gated by an enable.

Top module: `limp_supervisor`

## Requirements
- R1: The clock-present input passes through a two-flop synchronizer. A loss driven before edge n is seen as limp_o=1 after edge n+2. While limp_o=1, pll_sel_o=0.
- R2: A loss is acted on only when at least one of mon_en_i or fmon_en_i is 1. With both at 0, the loss has no effect on limp_o.
- R3: Entry to limp-home mode sets chg_flag_o on the same edge that changes limp_o, and so does exit. irq_o = chg_flag_o AND irq_en_i.
- R4: A 1 on flag_clr_i clears chg_flag_o at the next edge. If a set event falls on the same edge as a clear, the flag stays 1.
- R5: mon_on_o is 1 while limp_o=1. Otherwise it is mon_en_i OR fmon_en_i.
- R6: Each bit of mod_fb_o (bit 0 timer/watchdog group, bit 1 debug group, bit 2 timer/serial group) is 1 while limp_o=1 and 0 otherwise.
- R7: A free-running CNT_W-bit counter starts at 0 after reset and counts fallback edges. Exit happens only on the edge at which its value is 2^(CNT_W-1), and only if the synchronized clock-present input is 1. With CNT_W=13 the exits fall on edges 4097+8192k after reset.
- R8: On exit, pll_sel_o and mem_sel_o take the saved values. The saved values are the selects captured on the entry edge, or the values of the latest write made during limp-home mode.
- R9: relock_o pulses for one cycle, on the exit edge, when both the restored auto-lock bit and the restored PLL select bit are 1.
- R10: A write on sel_wr_i during limp-home mode does not change pll_sel_o or mem_sel_o while limp_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fb_i | input | 1 | Fallback clock (always running) |
| rst_ni | input | 1 | Active-low reset |
| clk_ok_i | input | 1 | Asynchronous clock-present indication |
| mon_en_i | input | 1 | Software clock monitor enable |
| fmon_en_i | input | 1 | Software fast clock monitor enable |
| sel_wr_i | input | 1 | Write strobe for the select bits |
| sel_pll_i | input | 1 | Write data: PLL select |
| sel_mem_i | input | 1 | Write data: memory clock select |
| sel_auto_i | input | 1 | Write data: auto-lock |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the change flag |
| limp_o | output | 1 | Limp-home mode status |
| chg_flag_o | output | 1 | Sticky mode-change flag |
| irq_o | output | 1 | Interrupt request |
| pll_sel_o | output | 1 | System clock PLL select |
| mem_sel_o | output | 1 | Memory clock select |
| mon_on_o | output | 1 | Effective clock monitor enable |
| mod_fb_o | output | N_MOD | Per-group force to the fallback clock |
| relock_o | output | 1 | One-cycle PLL relock request |

## Verification
A wrong mode state shows at the ports at once, because limp_o, pll_sel_o, mon_on_o and mod_fb_o all follow it on the same edge. A wrong poll counter may go unseen until the next expected exit edge, up to 8192 cycles later. The bench therefore checks the exit edge exactly, and also checks the edge just before it. A corrupted saved copy shows only on the exit edge, through pll_sel_o, mem_sel_o and relock_o. For that reason two recoveries are run with different saved contents.

// File: rtl/limp_pkg.sv
package limp_pkg;

   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_LIMP = 1'b1
   } limp_state_e;

   typedef struct packed {
      logic auto_lock;
      logic mem_sel;
      logic pll_sel;
   } clk_sel_t;

endpackage

// File: rtl/limp_sync.sv
module limp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("limp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/limp_poll_timer.sv
module limp_poll_timer #(
   parameter int CNT_W = 13
) (
   input  logic clk,
   input  logic rst_n,
   output logic poll_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("limp_poll_timer: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + ONE;
   end

   assign poll_o = (cnt_q == MID);
endmodule

// File: rtl/limp_sel_store.sv
module limp_sel_store
   import limp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     limp_i,
   input  logic     capture_i,
   input  logic     restore_i,
   input  logic     wr_i,
   input  clk_sel_t wdata_i,
   output logic     act_pll_o,
   output logic     act_mem_o,
   output logic     relock_cond_o
);
   clk_sel_t act_q, save_q, rest;

   // value the outputs take on the restore edge
   assign rest = wr_i ? wdata_i : save_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         save_q <= '0;
      end else if (capture_i) begin
         save_q <= wr_i ? wdata_i : act_q;
      end else if (limp_i && wr_i) begin
         save_q <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (restore_i) begin
         act_q <= rest;
      end else if (!limp_i && wr_i) begin
         act_q <= wdata_i;
      end
   end

   assign act_pll_o     = act_q.pll_sel;
   assign act_mem_o     = act_q.mem_sel;
   assign relock_cond_o = rest.auto_lock & rest.pll_sel;
endmodule

// File: rtl/limp_supervisor.sv
module limp_supervisor
   import limp_pkg::*;
#(
   parameter int               CNT_W       = 13,
   parameter int               SYNC_STAGES = 2,
   parameter int               N_MOD       = 3,
   parameter logic [N_MOD-1:0] FORCE_MASK  = '1
) (
   input  logic             clk_fb_i,
   input  logic             rst_ni,
   input  logic             clk_ok_i,
   input  logic             mon_en_i,
   input  logic             fmon_en_i,
   input  logic             sel_wr_i,
   input  logic             sel_pll_i,
   input  logic             sel_mem_i,
   input  logic             sel_auto_i,
   input  logic             irq_en_i,
   input  logic             flag_clr_i,
   output logic             limp_o,
   output logic             chg_flag_o,
   output logic             irq_o,
   output logic             pll_sel_o,
   output logic             mem_sel_o,
   output logic             mon_on_o,
   output logic [N_MOD-1:0] mod_fb_o,
   output logic             relock_o
);
   if (N_MOD < 1) begin : g_bad_nmod
      $error("limp_supervisor: N_MOD must be at least 1");
   end

   limp_state_e state_q, state_d;
   logic        ok_s, poll_stb, mon_eff, enter, leave;
   logic        act_pll, act_mem, relock_cond;
   logic        flag_q, relock_q;
   clk_sel_t    wdata;

   limp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk_fb_i),
      .rst_n (rst_ni),
      .d_i   (clk_ok_i),
      .q_o   (ok_s)
   );

   limp_poll_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk_fb_i),
      .rst_n  (rst_ni),
      .poll_o (poll_stb)
   );

   assign wdata = '{auto_lock: sel_auto_i, mem_sel: sel_mem_i, pll_sel: sel_pll_i};

   assign mon_eff = mon_en_i | fmon_en_i;
   assign enter   = (state_q == ST_RUN)  && mon_eff && !ok_s;
   assign leave   = (state_q == ST_LIMP) && poll_stb && ok_s;

   always_comb begin
      state_d = state_q;
      if (enter)      state_d = ST_LIMP;
      else if (leave) state_d = ST_RUN;
   end

   always_ff @(posedge clk_fb_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_RUN;
      else         state_q <= state_d;
   end

   limp_sel_store u_store (
      .clk           (clk_fb_i),
      .rst_n         (rst_ni),
      .limp_i        (state_q == ST_LIMP),
      .capture_i     (enter),
      .restore_i     (leave),
      .wr_i          (sel_wr_i),
      .wdata_i       (wdata),
      .act_pll_o     (act_pll),
      .act_mem_o     (act_mem),
      .relock_cond_o (relock_cond)
   );

   // set has priority over the clear strobe
   always_ff @(posedge clk_fb_i or negedge rst_ni) begin
      if (!rst_ni)              flag_q <= 1'b0;
      else if (enter || leave)  flag_q <= 1'b1;
      else if (flag_clr_i)      flag_q <= 1'b0;
   end

   always_ff @(posedge clk_fb_i or negedge rst_ni) begin
      if (!rst_ni) relock_q <= 1'b0;
      else         relock_q <= leave && relock_cond;
   end

   assign limp_o     = (state_q == ST_LIMP);
   assign chg_flag_o = flag_q;
   assign irq_o      = flag_q & irq_en_i;
   assign pll_sel_o  = act_pll & ~limp_o;
   assign mem_sel_o  = act_mem;
   assign mon_on_o   = limp_o | mon_eff;
   assign relock_o   = relock_q;

   for (genvar g = 0; g < N_MOD; g++) begin : g_modclk
      if (FORCE_MASK[g]) begin : g_forced
         assign mod_fb_o[g] = limp_o;
      end else begin : g_free
         assign mod_fb_o[g] = 1'b0;
      end
   end
endmodule

// File: rtl/limp_supervisor_chk.sv
module limp_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic limp,
   input logic flag,
   input logic irq,
   input logic irq_en,
   input logic clr,
   input logic pll,
   input logic mem,
   input logic mon,
   input logic relock,
   input logic poll
);
   p_pll_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      limp |-> !pll);

   p_entry_needs_monitor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(limp) |-> $past(mon));

   p_flag_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(limp) |-> flag);

   p_flag_on_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(limp) |-> flag);

   p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && irq_en));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr) && !$rose(limp) && !$fell(limp)) |-> !flag);

   p_monitor_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
      limp |-> mon);

   p_exit_on_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(limp) |-> $past(poll));

   p_relock_at_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      relock |-> $fell(limp));

   p_mem_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (limp && $past(limp)) |-> $stable(mem));
endmodule

bind limp_supervisor limp_supervisor_chk u_chk (
   .clk    (clk_fb_i),
   .rst_n  (rst_ni),
   .limp   (limp_o),
   .flag   (chg_flag_o),
   .irq    (irq_o),
   .irq_en (irq_en_i),
   .clr    (flag_clr_i),
   .pll    (pll_sel_o),
   .mem    (mem_sel_o),
   .mon    (mon_on_o),
   .relock (relock_o),
   .poll   (poll_stb)
);

// File: tb/limp_supervisor_test.sv
module limp_supervisor_test;
   localparam logic [9:0] B_FB = 10'h007, B_MON = 10'h008, B_MEM = 10'h010,
                          B_PLL = 10'h020, B_IRQ = 10'h040, B_FLG = 10'h080,
                          B_LIMP = 10'h100, B_RLK = 10'h200;

   typedef struct {
      int         cyc;
      logic [9:0] mask;
      logic [9:0] val;
      string      tag;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic clk_ok = 1, mon_en = 0, fmon_en = 0, wr = 0, wpll = 0, wmem = 0, wauto = 0;
   logic irq_en = 0, clr = 0;
   logic limp, flag, irq, pll, mem, mon, relock;
   logic [2:0] fb;
   logic [9:0] obs;
   int cyc = 0, nchk = 0, nerr = 0;
   bit done = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   limp_supervisor uut (
      .clk_fb_i(clk), .rst_ni(rst_n), .clk_ok_i(clk_ok), .mon_en_i(mon_en),
      .fmon_en_i(fmon_en), .sel_wr_i(wr), .sel_pll_i(wpll), .sel_mem_i(wmem),
      .sel_auto_i(wauto), .irq_en_i(irq_en), .flag_clr_i(clr),
      .limp_o(limp), .chg_flag_o(flag), .irq_o(irq), .pll_sel_o(pll),
      .mem_sel_o(mem), .mon_on_o(mon), .mod_fb_o(fb), .relock_o(relock)
   );

   assign obs = {relock, limp, flag, irq, pll, mem, mon, fb};

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // monitor: pops expected items when their cycle comes up
   always @(negedge clk) begin
      if (rst_n) begin
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t it;
            it = q.pop_front();
            nchk++;
            if (((obs ^ it.val) & it.mask) != 0) begin
               nerr++;
               $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                        it.tag, cyc, obs, it.val, it.mask);
            end
         end
      end
   end

   task automatic expect_at(input int c, input logic [9:0] m, input logic [9:0] v,
                            input string tag);
      exp_t it;
      it.cyc = c; it.mask = m; it.val = v; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic at_cycle(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic write_sel(input int n, input logic p, input logic m, input logic a);
      at_cycle(n);
      wr = 1; wpll = p; wmem = m; wauto = a;
      at_cycle(n + 1);
      wr = 0;
   endtask

   task automatic pulse_clr(input int n);
      at_cycle(n);
      clr = 1;
      at_cycle(n + 1);
      clr = 0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      nchk++;
      if (obs !== 10'b0) begin
         nerr++;
         $display("FAIL reset actual=%b expected=%b", obs, 10'b0);
      end
      rst_n = 1;

      // R8 setup: program selects in normal mode
      expect_at(11, B_PLL | B_MEM, B_PLL | B_MEM, "R8 normal write");
      write_sel(10, 1, 1, 1);

      // R2: loss while monitor disabled is ignored
      at_cycle(20); clk_ok = 0;
      expect_at(25, B_LIMP | B_MON, 10'h000, "R2 loss ignored");
      at_cycle(30); clk_ok = 1;

      // R5: monitor output follows software enable in normal mode
      at_cycle(40); mon_en = 1;
      expect_at(41, B_MON, B_MON, "R5 monitor enable");

      // R1/R3/R6: entry latency and forced outputs
      at_cycle(50); clk_ok = 0;
      expect_at(52, B_LIMP, 10'h000, "R1 no early entry");
      expect_at(53, 10'h3FF, B_LIMP | B_FLG | B_MEM | B_MON | B_FB,
                "R1 R3 R6 entry");

      // R5: monitor forced on during limp-home
      at_cycle(60); mon_en = 0;
      expect_at(61, B_MON, B_MON, "R5 forced monitor");

      // R4: clear strobe
      expect_at(71, B_FLG, 10'h000, "R4 clear");
      pulse_clr(70);

      // R10: write during limp does not reach outputs
      expect_at(81, B_PLL | B_MEM, B_MEM, "R10 write held");
      write_sel(80, 1, 0, 1);

      at_cycle(90); irq_en = 1;
      expect_at(91, B_IRQ, 10'h000, "R3 irq needs flag");

      // R7: poll with clock still absent
      expect_at(4098, B_LIMP, B_LIMP, "R7 poll clock absent");
      at_cycle(5000); clk_ok = 1;
      expect_at(12288, B_LIMP, B_LIMP, "R7 no exit before poll");
      expect_at(12289, 10'h3FF, B_RLK | B_FLG | B_IRQ | B_PLL,
                "R7 R8 R9 R3 exit restore");
      expect_at(12290, B_RLK, 10'h000, "R9 relock one cycle");

      // R4: set wins over a simultaneous clear
      at_cycle(12300); mon_en = 1;
      at_cycle(12310); clk_ok = 0;
      expect_at(12313, B_LIMP | B_FLG, B_LIMP | B_FLG, "R4 set wins");
      pulse_clr(12312);
      expect_at(12321, B_FLG | B_IRQ, 10'h000, "R4 clear again");
      pulse_clr(12320);
      expect_at(12331, B_PLL | B_MEM, 10'h000, "R10 write held 2");
      write_sel(12330, 0, 1, 1);

      // R8/R9: second recovery with different saved contents
      at_cycle(13000); clk_ok = 1;
      expect_at(20481, B_LIMP | B_PLL | B_MEM | B_RLK | B_FLG, B_MEM | B_FLG,
                "R8 R9 exit no relock");

      // R2: fast monitor enable alone detects a loss
      at_cycle(20500); mon_en = 0; fmon_en = 1;
      at_cycle(20510); clk_ok = 0;
      expect_at(20512, B_LIMP, 10'h000, "R2 fast monitor latency");
      expect_at(20513, B_LIMP | B_MON | B_FB, B_LIMP | B_MON | B_FB,
                "R2 R6 fast monitor entry");

      at_cycle(20520);
      while (q.size() > 0) @(negedge clk);
      done = 1;
      finish_run();
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog cyc=%0d actual=running expected=done", cyc);
         finish_run();
      end
   end
endmodule